// File: doc/BRIEF.md
# Command and Data Routing Bus Controller

This block sits behind a 16-bit shared bus driven by an external host. The bus has three active-low controls: chip enable, write enable and command enable. The controller samples the bus with the system clock and sorts each access into one of four kinds: command write, command read, data write or data read. It then names the internal resource that the access reaches and the 16-bit segment of that resource. It also decodes a small instruction set that arrives through command writes.

Data accesses go to a persistent source, for reads, and a persistent destination, for writes. Each one stays selected until an instruction changes it. Command accesses go by default to the instruction decoder when writing and to the status register when reading. A one-shot override instruction redirects only the next command access to an auxiliary register, or to a readback of the persistent choices. A segment counter for each direction advances at the end of each data access, so four accesses in a row cover a 64-bit word.

Top module: `bus_ctl`

## Requirements
- R1: An access begins on the first clock at which `ce_n` is sampled low. At that clock, `cm_n` low marks a command access and `cm_n` high marks a data access. `we_n` low marks a write and `we_n` high marks a read. The access ends on the first clock at which `ce_n` is sampled high again.
- R2: With no override pending, a command write reaches the instruction decoder and raises no write strobe. A command read selects the status register, which has resource code 4.
- R3: An override instruction sets a pending target. The next command access, read or write, goes to that target, and the override then lapses. Data accesses do not use up a pending override.
- R4: After reset, the persistent source and destination are both the comparand (code 0). A source-select instruction changes only the source, and a destination-select instruction changes only the destination.
- R5: An instruction holds its opcode in bits 15:12 and its target code in bits 3:0. Opcode 1 selects the source, opcode 2 selects the destination and opcode 3 is the override. The persistent targets are comparand 0, mask-1 1, mask-2 2 and array 3. The override targets are control 5, segment-control 6, address 7, next-free 8, source readback 9 and destination readback 10. An unknown opcode, or a target outside the range allowed for its opcode, changes nothing.
- R6: The source segment counter steps at the end of each data read, and the destination segment counter steps at the end of each data write. Both counters wrap from 3 to 0. Selecting a new source or destination clears the matching counter to 0.
- R7: A write to a writable resource raises `wr_stb` for exactly one clock, on the clock after `ce_n` is sampled high. At that time `wr_sel`, `wr_seg` and `wr_data` hold the target, the segment and the bus data captured when the access began. The readback targets 9 and 10 are not writable.
- R8: `dq_oe` is high only while a read access is in progress and `ce_n` is low.
- R9: During an override read of target 9 or 10, `dq_out` carries the persistent source code or the persistent destination code in bits 3:0, with zeros above. On any other read, `dq_out` carries `rsrc_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Bus chip enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| cm_n | input | 1 | Bus command enable, active low |
| dq_in | input | 16 | Bus write data |
| rsrc_rdata | input | 16 | Read data from the selected resource |
| dq_out | output | 16 | Bus read data |
| dq_oe | output | 1 | Bus output drive enable |
| wr_stb | output | 1 | One-clock write commit strobe |
| wr_sel | output | 4 | Resource code of the committed write |
| wr_seg | output | 2 | Segment of the committed write |
| wr_data | output | 16 | Data of the committed write |
| rd_sel | output | 4 | Resource code of the current read |
| rd_seg | output | 2 | Segment of the current read |

## Verification
The properties assume that the bus is synchronous to `clk` and follows a few rules. `ce_n` stays low for at least one clock and then high for at least one clock. `we_n`, `cm_n` and `dq_in` are held steady from the falling edge of `ce_n` until it rises again. Under these rules a write strobe can never follow another write strobe directly, and a change in segment count always means one step forward or a clear. The bench keeps within these rules: it changes inputs only on the falling clock edge, holds `ce_n` low for two clocks and high for two clocks in every access, and never changes the control lines in the middle of an access.

// File: rtl/bus_ctl_pkg.sv
package bus_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CMD_WR = 3'd1,
        ST_CMD_RD = 3'd2,
        ST_DAT_WR = 3'd3,
        ST_DAT_RD = 3'd4
    } cyc_state_e;

    typedef enum logic [3:0] {
        RS_CMPR    = 4'd0,
        RS_MASK1   = 4'd1,
        RS_MASK2   = 4'd2,
        RS_ARRAY   = 4'd3,
        RS_STATUS  = 4'd4,
        RS_CTRL    = 4'd5,
        RS_SEGCTL  = 4'd6,
        RS_ADDR    = 4'd7,
        RS_NFREE   = 4'd8,
        RS_PSRC    = 4'd9,
        RS_PDST    = 4'd10,
        RS_DECODER = 4'd14,
        RS_NONE    = 4'd15
    } rsrc_e;

    localparam logic [3:0] OP_SEL_SRC = 4'h1;
    localparam logic [3:0] OP_SEL_DST = 4'h2;
    localparam logic [3:0] OP_OVRD    = 4'h3;

    function automatic logic is_persist(input logic [3:0] code);
        return code <= 4'd3;
    endfunction

    function automatic logic is_aux(input logic [3:0] code);
        return (code >= 4'd5) && (code <= 4'd10);
    endfunction

    function automatic logic is_writable(input rsrc_e code);
        return (code != RS_DECODER) && (code != RS_PSRC) &&
               (code != RS_PDST) && (code != RS_STATUS) && (code != RS_NONE);
    endfunction

endpackage

// File: rtl/bus_ctl_fsm.sv
module bus_ctl_fsm
    import bus_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       we_n,
    input  logic       cm_n,
    output cyc_state_e state,
    output cyc_state_e nxt_state,
    output logic       cyc_start,
    output logic       cyc_end
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    always_comb begin
        nxt_state = state;
        cyc_start = 1'b0;
        cyc_end   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!ce_n) begin
                    cyc_start = 1'b1;
                    if (!cm_n) nxt_state = we_n ? ST_CMD_RD : ST_CMD_WR;
                    else       nxt_state = we_n ? ST_DAT_RD : ST_DAT_WR;
                end
            end
            ST_CMD_WR, ST_CMD_RD, ST_DAT_WR, ST_DAT_RD: begin
                if (ce_n) begin
                    cyc_end   = 1'b1;
                    nxt_state = ST_IDLE;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/bus_ctl_seg.sv
module bus_ctl_seg #(
    parameter int SEG_CNT = 4,
    parameter int SEG_W   = $clog2(SEG_CNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [SEG_W-1:0] seg
);

    localparam logic [SEG_W-1:0] SEG_LAST = SEG_W'(SEG_CNT - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    seg <= '0;
        else if (clr)  seg <= '0;
        else if (step) seg <= (seg == SEG_LAST) ? '0 : seg + 1'b1;
    end

endmodule

// File: rtl/bus_ctl_route.sv
module bus_ctl_route
    import bus_ctl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_state_e        state,
    input  cyc_state_e        nxt_state,
    input  logic              cyc_start,
    input  logic              cyc_end,
    input  logic [DATA_W-1:0] dq_in,
    input  logic [SEG_W-1:0]  src_seg,
    input  logic [SEG_W-1:0]  dst_seg,
    output rsrc_e             psrc,
    output rsrc_e             pdst,
    output logic              tco_pend,
    output rsrc_e             sel_cap,
    output logic [SEG_W-1:0]  seg_cap,
    output logic [DATA_W-1:0] data_cap,
    output logic              wr_stb,
    output logic [1:0]        seg_clr
);

    localparam int OPC_LSB = DATA_W - 4;

    rsrc_e      tco_tgt;
    logic [3:0] opc;
    logic [3:0] tgt;
    logic       exec;
    logic       do_sps;
    logic       do_spd;
    logic       do_tco;
    logic       is_cmd;
    logic       is_wr;

    always_comb begin
        opc     = data_cap[OPC_LSB +: 4];
        tgt     = data_cap[3:0];
        is_cmd  = (state == ST_CMD_WR) || (state == ST_CMD_RD);
        is_wr   = (state == ST_CMD_WR) || (state == ST_DAT_WR);
        exec    = cyc_end && (state == ST_CMD_WR) && (sel_cap == RS_DECODER);
        do_sps  = exec && (opc == OP_SEL_SRC) && is_persist(tgt);
        do_spd  = exec && (opc == OP_SEL_DST) && is_persist(tgt);
        do_tco  = exec && (opc == OP_OVRD) && is_aux(tgt);
        seg_clr = {do_spd, do_sps};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psrc     <= RS_CMPR;
            pdst     <= RS_CMPR;
            tco_pend <= 1'b0;
            tco_tgt  <= RS_NONE;
            sel_cap  <= RS_NONE;
            seg_cap  <= '0;
            data_cap <= '0;
            wr_stb   <= 1'b0;
        end else begin
            wr_stb <= cyc_end && is_wr && is_writable(sel_cap);
            if (cyc_start) begin
                data_cap <= dq_in;
                seg_cap  <= '0;
                unique case (nxt_state)
                    ST_CMD_WR: sel_cap <= tco_pend ? tco_tgt : RS_DECODER;
                    ST_CMD_RD: sel_cap <= tco_pend ? tco_tgt : RS_STATUS;
                    ST_DAT_WR: begin
                        sel_cap <= pdst;
                        seg_cap <= dst_seg;
                    end
                    ST_DAT_RD: begin
                        sel_cap <= psrc;
                        seg_cap <= src_seg;
                    end
                    default: sel_cap <= RS_NONE;
                endcase
            end
            if (do_sps) psrc <= rsrc_e'(tgt);
            if (do_spd) pdst <= rsrc_e'(tgt);
            if (cyc_end && is_cmd && tco_pend) tco_pend <= 1'b0;
            if (do_tco) begin
                tco_pend <= 1'b1;
                tco_tgt  <= rsrc_e'(tgt);
            end
        end
    end

endmodule

// File: rtl/bus_ctl.sv
module bus_ctl
    import bus_ctl_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SEG_CNT = 4,
    parameter int SEG_W   = $clog2(SEG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              cm_n,
    input  logic [DATA_W-1:0] dq_in,
    input  logic [DATA_W-1:0] rsrc_rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              wr_stb,
    output logic [3:0]        wr_sel,
    output logic [SEG_W-1:0]  wr_seg,
    output logic [DATA_W-1:0] wr_data,
    output logic [3:0]        rd_sel,
    output logic [SEG_W-1:0]  rd_seg
);

    cyc_state_e        state;
    cyc_state_e        nxt_state;
    logic              cyc_start;
    logic              cyc_end;
    rsrc_e             psrc;
    rsrc_e             pdst;
    rsrc_e             sel_cap;
    logic              tco_pend;
    logic [SEG_W-1:0]  seg_cap;
    logic [DATA_W-1:0] data_cap;
    logic [1:0]        seg_clr;
    logic [1:0]        seg_step;
    logic [SEG_W-1:0]  seg_q [2];
    logic [SEG_W-1:0]  src_seg;
    logic [SEG_W-1:0]  dst_seg;

    bus_ctl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .cm_n      (cm_n),
        .state     (state),
        .nxt_state (nxt_state),
        .cyc_start (cyc_start),
        .cyc_end   (cyc_end)
    );

    assign seg_step[0] = cyc_end && (state == ST_DAT_RD);
    assign seg_step[1] = cyc_end && (state == ST_DAT_WR);

    for (genvar g = 0; g < 2; g++) begin : g_seg
        bus_ctl_seg #(.SEG_CNT(SEG_CNT), .SEG_W(SEG_W)) u_seg (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (seg_clr[g]),
            .step  (seg_step[g]),
            .seg   (seg_q[g])
        );
    end

    assign src_seg = seg_q[0];
    assign dst_seg = seg_q[1];

    bus_ctl_route #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .nxt_state (nxt_state),
        .cyc_start (cyc_start),
        .cyc_end   (cyc_end),
        .dq_in     (dq_in),
        .src_seg   (src_seg),
        .dst_seg   (dst_seg),
        .psrc      (psrc),
        .pdst      (pdst),
        .tco_pend  (tco_pend),
        .sel_cap   (sel_cap),
        .seg_cap   (seg_cap),
        .data_cap  (data_cap),
        .wr_stb    (wr_stb),
        .seg_clr   (seg_clr)
    );

    assign dq_oe   = ((state == ST_CMD_RD) || (state == ST_DAT_RD)) && !ce_n;
    assign wr_sel  = sel_cap;
    assign wr_seg  = seg_cap;
    assign wr_data = data_cap;
    assign rd_sel  = sel_cap;
    assign rd_seg  = seg_cap;

    always_comb begin
        if (sel_cap == RS_PSRC)      dq_out = {{(DATA_W-4){1'b0}}, psrc};
        else if (sel_cap == RS_PDST) dq_out = {{(DATA_W-4){1'b0}}, pdst};
        else                         dq_out = rsrc_rdata;
    end

endmodule

// File: rtl/bus_ctl_chk.sv
module bus_ctl_chk
    import bus_ctl_pkg::*;
#(
    parameter int SEG_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             dq_oe,
    input logic             wr_stb,
    input logic [3:0]       wr_sel,
    input cyc_state_e       state,
    input logic             cyc_end,
    input logic             tco_pend,
    input rsrc_e            psrc,
    input rsrc_e            pdst,
    input logic [SEG_W-1:0] src_seg,
    input logic [SEG_W-1:0] dst_seg
);

    AST_OE_ONLY_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !ce_n) else $error("dq_oe with ce_n high"); // R8

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb) else $error("wr_stb held"); // R7

    AST_STB_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_stb) |-> $past(ce_n)) else $error("wr_stb without ce_n high"); // R7

    AST_STB_TARGET_OK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_sel != 4'(RS_DECODER)) && (wr_sel != 4'(RS_PSRC)) &&
                   (wr_sel != 4'(RS_PDST)) && (wr_sel != 4'(RS_STATUS)))
        else $error("strobe to non-writable target"); // R2

    AST_PERSIST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (4'(psrc) <= 4'd3) && (4'(pdst) <= 4'd3)) else $error("bad persistent code"); // R4

    AST_SRC_SEG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (src_seg != $past(src_seg)) |-> ((src_seg == '0) || (src_seg == $past(src_seg) + 1'b1)))
        else $error("source segment jump"); // R6

    AST_DST_SEG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_seg != $past(dst_seg)) |-> ((dst_seg == '0) || (dst_seg == $past(dst_seg) + 1'b1)))
        else $error("destination segment jump"); // R6

    AST_OVRD_LAPSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tco_pend && cyc_end && ((state == ST_CMD_WR) || (state == ST_CMD_RD))) |=> !tco_pend)
        else $error("override did not lapse"); // R3

endmodule

bind bus_ctl bus_ctl_chk #(.SEG_W(SEG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .dq_oe    (dq_oe),
    .wr_stb   (wr_stb),
    .wr_sel   (wr_sel),
    .state    (state),
    .cyc_end  (cyc_end),
    .tco_pend (tco_pend),
    .psrc     (psrc),
    .pdst     (pdst),
    .src_seg  (src_seg),
    .dst_seg  (dst_seg)
);

// File: tb/bus_ctl_bench.sv
module bus_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        cm_n = 1'b1;
    logic [15:0] dq_in = '0;
    logic [15:0] rsrc_rdata;
    logic [15:0] dq_out;
    logic        dq_oe;
    logic        wr_stb;
    logic [3:0]  wr_sel;
    logic [1:0]  wr_seg;
    logic [15:0] wr_data;
    logic [3:0]  rd_sel;
    logic [1:0]  rd_seg;

    int checks = 0;
    int errors = 0;

    logic [21:0] exp_q [$];

    logic [3:0] m_psrc = 4'd0;
    logic [3:0] m_pdst = 4'd0;
    logic [1:0] m_sseg = 2'd0;
    logic [1:0] m_dseg = 2'd0;
    bit         m_ovr  = 1'b0;
    logic [3:0] m_otgt = 4'd0;

    always #10 clk = ~clk;

    assign rsrc_rdata = {4'hA, rd_sel, 6'b0, rd_seg};

    bus_ctl u_bus_ctl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cm_n(cm_n),
        .dq_in(dq_in), .rsrc_rdata(rsrc_rdata), .dq_out(dq_out), .dq_oe(dq_oe),
        .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_seg(wr_seg), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_seg(rd_seg)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every write strobe (R7)
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected wr_stb", {10'b0, wr_sel, wr_seg, wr_data}, 32'h0);
            end else begin
                logic [21:0] e;
                e = exp_q.pop_front();
                chk({wr_sel, wr_seg, wr_data} == e, "R7", "write sel/seg/data",
                    {10'b0, wr_sel, wr_seg, wr_data}, {10'b0, e});
            end
        end
    end

    task automatic bus_write(input bit cmd, input logic [15:0] d);
        @(negedge clk);
        cm_n = ~cmd; we_n = 1'b0; dq_in = d; ce_n = 1'b0;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; cm_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_read(input bit cmd, input logic [3:0] esel, input logic [1:0] eseg,
                            input logic [15:0] edq, input string req);
        @(negedge clk);
        cm_n = ~cmd; we_n = 1'b1; ce_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(dq_oe == 1'b1, "R8", "dq_oe during read", {31'b0, dq_oe}, 32'h1);
        chk(rd_sel == esel, req, "rd_sel", {28'b0, rd_sel}, {28'b0, esel});
        chk(rd_seg == eseg, req, "rd_seg", {30'b0, rd_seg}, {30'b0, eseg});
        chk(dq_out == edq, req, "dq_out", {16'b0, dq_out}, {16'b0, edq});
        ce_n = 1'b1; cm_n = 1'b1;
        #1;
        chk(dq_oe == 1'b0, "R8", "dq_oe after ce_n rise", {31'b0, dq_oe}, 32'h0);
        repeat (2) @(negedge clk);
    endtask

    task automatic data_wr(input logic [15:0] d);
        exp_q.push_back({m_pdst, m_dseg, d});
        m_dseg = m_dseg + 2'd1;
        bus_write(1'b0, d);
    endtask

    task automatic data_rd(input string req);
        bus_read(1'b0, m_psrc, m_sseg, {4'hA, m_psrc, 6'b0, m_sseg}, req);
        m_sseg = m_sseg + 2'd1;
    endtask

    task automatic cmd_wr(input logic [15:0] d);
        if (m_ovr) begin
            if (m_otgt >= 4'd5 && m_otgt <= 4'd8) exp_q.push_back({m_otgt, 2'b0, d});
            m_ovr = 1'b0;
        end else begin
            if (d[15:12] == 4'h1 && d[3:0] <= 4'd3) begin m_psrc = d[3:0]; m_sseg = 2'd0; end
            if (d[15:12] == 4'h2 && d[3:0] <= 4'd3) begin m_pdst = d[3:0]; m_dseg = 2'd0; end
            if (d[15:12] == 4'h3 && d[3:0] >= 4'd5 && d[3:0] <= 4'd10) begin
                m_ovr = 1'b1; m_otgt = d[3:0];
            end
        end
        bus_write(1'b1, d);
    endtask

    task automatic cmd_rd(input string req);
        logic [3:0]  s;
        logic [15:0] v;
        s = m_ovr ? m_otgt : 4'd4;
        if (s == 4'd9)       v = {12'b0, m_psrc};
        else if (s == 4'd10) v = {12'b0, m_pdst};
        else                 v = {4'hA, s, 6'b0, 2'b0};
        m_ovr = 1'b0;
        bus_read(1'b1, s, 2'd0, v, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_stb == 1'b0, "R7", "reset wr_stb", {31'b0, wr_stb}, 32'h0);
        chk(dq_oe == 1'b0, "R8", "reset dq_oe", {31'b0, dq_oe}, 32'h0);

        // R1 R4: default data source and destination are the comparand
        data_rd("R1");
        repeat (5) data_wr(16'h1234 + 16'(exp_q.size()));   // R6 wrap 0..3,0
        // R2: command read defaults to status, command write to decoder
        cmd_rd("R2");
        cmd_wr(16'h2002);        // R5 select destination mask-2, R6 clear
        data_wr(16'hBEEF);
        data_rd("R4");           // source unchanged by destination select
        cmd_wr(16'h1003);        // source array
        data_rd("R6");
        data_rd("R6");
        // R3: override to control, then lapse
        cmd_wr(16'h3005);
        cmd_wr(16'hC0DE);
        cmd_wr(16'h1001);        // decoded again: source mask-1
        data_rd("R3");
        cmd_rd("R3");
        // R3: data access does not consume override
        cmd_wr(16'h3007);
        data_wr(16'h5555);
        cmd_rd("R3");
        cmd_rd("R3");
        // R9: readbacks
        cmd_wr(16'h3009);
        cmd_rd("R9");
        cmd_wr(16'h300A);
        cmd_rd("R9");
        // R7: readback target write gives no strobe, override lapses
        cmd_wr(16'h3009);
        cmd_wr(16'h7777);
        cmd_rd("R7");
        // R5: unknown opcode and out-of-range targets ignored
        data_rd("R5");
        cmd_wr(16'h7003);
        cmd_wr(16'h1008);
        cmd_wr(16'h3004);
        data_rd("R5");
        cmd_rd("R5");
        data_wr(16'hA5A5);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "missing strobes", exp_q.size(), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        chk(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule